// File: doc/BRIEF.md
# Table-Driven Event Sequencer

The block is a small autonomous controller. It runs a program of steps kept in an internal table RAM. Each table row names an action and an event condition. The action is one of: halt, step, wait, or one of four conditional jumps. The row also carries a jump target, a count value, four GPIO enable bits and a flag that raises an output trigger. While the controller runs, it executes one row per clock cycle. A wait row stays in place until its condition becomes true, and a jump row picks between its target and the following row. A single down-counter serves two purposes. A wait row uses it as an interval timer, and a jump row uses it as a loop counter.

Events arrive as a vector and come in two kinds. Sticky events are latched and stay set until the program consumes them. This class covers four trigger lines, each formed as the OR of a firmware bit and a hardware bit, plus a group of external sticky lines. Live events go straight to the condition logic and are never latched. Software loads the table through a write port while the controller is stopped. It then controls the run with start, stop and pause strobes and reads back the run state and the current row index.

Top module: `evseq_top`

## Requirements
- R1: A table row is a 24-bit word with these fields: action [23:21], condition select [20:17], jump target [16:13], count [12:5], GPIO enables [4:1] and trigger flag [0]. A row written through the table port is the one used the next time that index executes.
- R2: The run state reads 0 when stopped, 1 when running and 2 when paused, and it is 0 after reset. In any state, a stop strobe returns the block to stopped with row index 0 and GPIO outputs 0. A start strobe while stopped begins running at row 0.
- R3: Action codes: 0 is halt, 1 is step, 2 is wait, 3 is jump-if-true, 4 is jump-if-false, 5 is jump-if-true-and-clear, 6 is jump-if-false-and-clear. Code 7 behaves as halt. A step row moves to the next index, one row per cycle. A halt row returns the block to stopped at index 0.
- R4: A wait row stays at its index for as long as its condition is false, with no limit. In the first cycle in which the condition is true, it moves to the next index.
- R5: The true-jump codes (3 and 5) go to the target when the condition is true and to the next index when it is false. The false-jump codes (4 and 6) do the opposite.
- R6: Condition select encoding: 0 is false, 1 is true, 2 is counter done, 3 to 6 are trigger events 0 to 3, 7 to 10 are external sticky events 0 to 3, 11 to 14 are live events 0 to 3, and 15 is false.
- R7: A wait row that selects counter done with count N executes N+1 times before it advances. Count 0 advances on the first execution.
- R8: A jump-if-false row that selects counter done with count N, whose target points back to a loop body, makes the body run N+1 times. The counter re-arms for the next use of the loop.
- R9: A sticky event is set when its source is high at a clock edge. Trigger events use the OR of the firmware bit and the hardware bit. A wait row clears the event it selects when it passes. Codes 5 and 6 clear the selected event every time they evaluate. Codes 3 and 4 leave the event set. If a set and a clear hit the same event in the same cycle, the set wins.
- R10: Live events are not latched. A pulse that ends before the row evaluates has no effect.
- R11: gpio_o shows the enables of the row executed in the previous cycle. gpio_o is 0 after a halt or a stop. trig_o pulses for one cycle when a flagged row is entered, and it does not repeat while a wait row holds.
- R12: A pause strobe while running freezes the row index, the counter and the outputs. A start strobe while paused resumes the run. A pause strobe while stopped, and a start strobe while running, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Start or resume strobe |
| ctl_stop | input | 1 | Stop strobe |
| ctl_pause | input | 1 | Pause strobe |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | AW | Table write index |
| tbl_wdata | input | EW | Table row data |
| fw_trig | input | 4 | Firmware trigger bits |
| hw_trig | input | 4 | Hardware trigger lines |
| ev_sticky | input | N_XST | External sticky event sources |
| ev_live | input | N_XTR | Live (transparent) events |
| run_state | output | 2 | 0 stopped, 1 running, 2 paused |
| cur_idx | output | AW | Index of the row to execute |
| gpio_o | output | 4 | GPIO enables of the last executed row |
| trig_o | output | 1 | Output trigger pulse |

## Verification
Two things can land on the same sticky flag in the same cycle: the program consuming and clearing an event, and a new arrival of that event. The bench arranges this with two wait rows that both select trigger 0. It drives the trigger for one cycle in one run and for two consecutive cycles in another run. The second cycle of the two-cycle drive lines up exactly with the edge at which the first wait row clears the flag. The result is judged at the index and state outputs. A one-cycle pulse must leave the program parked at the second wait row. A two-cycle pulse must carry it through both wait rows to the halt. A similar collision between the loop counter reload and its countdown is covered by sweeping loop counts and counting the output trigger pulses.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
  localparam logic [2:0] ACT_HALT   = 3'd0;
  localparam logic [2:0] ACT_STEP   = 3'd1;
  localparam logic [2:0] ACT_WAIT   = 3'd2;
  localparam logic [2:0] ACT_JT     = 3'd3;
  localparam logic [2:0] ACT_JF     = 3'd4;
  localparam logic [2:0] ACT_JT_CLR = 3'd5;
  localparam logic [2:0] ACT_JF_CLR = 3'd6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } run_e;

  localparam int SEL_FALSE = 0;
  localparam int SEL_TRUE  = 1;
  localparam int SEL_CNT   = 2;
  localparam int SEL_STK0  = 3;
  localparam int N_TRIG    = 4;
  localparam int N_GPIO    = 4;
  localparam int ACT_W     = 3;
endpackage

// File: rtl/evseq_table.sv
module evseq_table #(
  parameter int AW = 4,
  parameter int EW = 24,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evseq_events.sv
module evseq_events
  import evseq_pkg::*;
#(
  parameter int N_XST = 4,
  parameter int N_XTR = 4,
  parameter int CW    = 4,
  localparam int NS   = N_TRIG + N_XST,
  localparam int NSRC = SEL_STK0 + NS + N_XTR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] fw_trig,
  input  logic [N_TRIG-1:0] hw_trig,
  input  logic [N_XST-1:0]  ev_sticky,
  input  logic [N_XTR-1:0]  ev_live,
  input  logic [CW-1:0]     sel,
  input  logic              cnt_done,
  input  logic              clr_en,
  output logic              cond
);
  logic [NS-1:0]      stk_q;
  logic [NS-1:0]      set_v;
  logic [NS-1:0]      clr_v;
  logic [2**CW-1:0]   src_pad;

  assign set_v = {ev_sticky, fw_trig | hw_trig};

  always_comb begin
    for (int i = 0; i < NS; i++)
      clr_v[i] = clr_en && (int'(sel) == SEL_STK0 + i);
  end

  // a new arrival outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) stk_q <= '0;
    else     stk_q <= (stk_q & ~clr_v) | set_v;
  end

  always_comb begin
    src_pad = '0;
    src_pad[NSRC-1:0] = {ev_live, stk_q, cnt_done, 1'b1, 1'b0};
  end

  assign cond = src_pad[sel];
endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
  import evseq_pkg::*;
#(
  parameter int AW   = 4,
  parameter int CNTW = 8,
  parameter int CW   = 4,
  localparam int OFF_IT  = 0,
  localparam int OFF_GP  = 1,
  localparam int OFF_CNT = OFF_GP + N_GPIO,
  localparam int OFF_TGT = OFF_CNT + CNTW,
  localparam int OFF_CND = OFF_TGT + AW,
  localparam int OFF_ACT = OFF_CND + CW,
  localparam int EW      = OFF_ACT + ACT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              pause,
  input  logic [EW-1:0]     entry,
  input  logic              cond,
  output logic [CW-1:0]     sel,
  output logic              clr_en,
  output logic              cnt_done,
  output logic [AW-1:0]     pc_d,
  output run_e              st_q,
  output logic [AW-1:0]     pc_q,
  output logic [N_GPIO-1:0] gpio_q,
  output logic              trig_q
);
  logic [ACT_W-1:0]  act;
  logic [AW-1:0]     tgt;
  logic [CNTW-1:0]   cnt_f, cnt_q, cnt_d, cnt_eff;
  logic [N_GPIO-1:0] gp, gpio_d;
  logic              itr, fresh_q, fresh_d, loop_q, loop_d, trig_d, use_cnt, take;
  run_e              st_d;

  assign act     = entry[OFF_ACT +: ACT_W];
  assign sel     = entry[OFF_CND +: CW];
  assign tgt     = entry[OFF_TGT +: AW];
  assign cnt_f   = entry[OFF_CNT +: CNTW];
  assign gp      = entry[OFF_GP +: N_GPIO];
  assign itr     = entry[OFF_IT];
  assign use_cnt = (int'(sel) == SEL_CNT);

  // interval use reloads on entry; loop use reloads when not armed
  always_comb begin
    if (act == ACT_WAIT) cnt_eff = fresh_q ? cnt_f : cnt_q;
    else                 cnt_eff = loop_q ? cnt_q : cnt_f;
  end
  assign cnt_done = (cnt_eff == '0);

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    fresh_d = fresh_q;
    cnt_d   = cnt_q;
    loop_d  = loop_q;
    gpio_d  = gpio_q;
    trig_d  = 1'b0;
    clr_en  = 1'b0;
    take    = 1'b0;
    if (stop) begin
      st_d = ST_IDLE; pc_d = '0; gpio_d = '0; fresh_d = 1'b1; loop_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_d = ST_RUN; pc_d = '0; fresh_d = 1'b1; loop_d = 1'b0;
        end
        ST_HOLD: if (start) st_d = ST_RUN;
        ST_RUN: begin
          if (pause) st_d = ST_HOLD;
          else begin
            gpio_d = gp;
            trig_d = fresh_q & itr;
            case (act)
              ACT_STEP: begin
                pc_d = pc_q + 1'b1; fresh_d = 1'b1;
              end
              ACT_WAIT: begin
                if (use_cnt && !cnt_done) cnt_d = cnt_eff - 1'b1;
                if (cond) begin
                  pc_d = pc_q + 1'b1; fresh_d = 1'b1; clr_en = 1'b1;
                end else fresh_d = 1'b0;
              end
              ACT_JT, ACT_JF, ACT_JT_CLR, ACT_JF_CLR: begin
                take    = (act == ACT_JT || act == ACT_JT_CLR) ? cond : !cond;
                pc_d    = take ? tgt : pc_q + 1'b1;
                fresh_d = 1'b1;
                clr_en  = (act == ACT_JT_CLR || act == ACT_JF_CLR);
                if (use_cnt) begin
                  if (cnt_done) loop_d = 1'b0;
                  else begin
                    cnt_d = cnt_eff - 1'b1; loop_d = 1'b1;
                  end
                end
              end
              default: begin
                st_d = ST_IDLE; pc_d = '0; gpio_d = '0; fresh_d = 1'b1; loop_d = 1'b0;
              end
            endcase
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
      loop_q  <= 1'b0;
      gpio_q  <= '0;
      trig_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      fresh_q <= fresh_d;
      cnt_q   <= cnt_d;
      loop_q  <= loop_d;
      gpio_q  <= gpio_d;
      trig_q  <= trig_d;
    end
  end
endmodule

// File: rtl/evseq_top.sv
module evseq_top
  import evseq_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNTW  = 8,
  parameter int N_XST = 4,
  parameter int N_XTR = 4,
  localparam int NSRC = SEL_STK0 + N_TRIG + N_XST + N_XTR,
  localparam int CW   = $clog2(NSRC),
  localparam int EW   = ACT_W + CW + AW + CNTW + N_GPIO + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  input  logic              ctl_pause,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_waddr,
  input  logic [EW-1:0]     tbl_wdata,
  input  logic [N_TRIG-1:0] fw_trig,
  input  logic [N_TRIG-1:0] hw_trig,
  input  logic [N_XST-1:0]  ev_sticky,
  input  logic [N_XTR-1:0]  ev_live,
  output logic [1:0]        run_state,
  output logic [AW-1:0]     cur_idx,
  output logic [N_GPIO-1:0] gpio_o,
  output logic              trig_o
);
  logic [EW-1:0] entry;
  logic [CW-1:0] sel;
  logic [AW-1:0] pc_d;
  logic          cond, clr_en, cnt_done;
  run_e          st_q;

  evseq_table #(.AW(AW), .EW(EW)) table_i (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(pc_d), .rdata(entry)
  );

  evseq_events #(.N_XST(N_XST), .N_XTR(N_XTR), .CW(CW)) events_i (
    .clk(clk), .rst(rst), .fw_trig(fw_trig), .hw_trig(hw_trig),
    .ev_sticky(ev_sticky), .ev_live(ev_live), .sel(sel),
    .cnt_done(cnt_done), .clr_en(clr_en), .cond(cond)
  );

  evseq_ctrl #(.AW(AW), .CNTW(CNTW), .CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .start(ctl_start), .stop(ctl_stop), .pause(ctl_pause),
    .entry(entry), .cond(cond), .sel(sel), .clr_en(clr_en), .cnt_done(cnt_done),
    .pc_d(pc_d), .st_q(st_q), .pc_q(cur_idx), .gpio_q(gpio_o), .trig_q(trig_o)
  );

  assign run_state = st_q;
endmodule

// File: rtl/evseq_chk.sv
module evseq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_start,
  input logic          ctl_stop,
  input logic [1:0]    run_state,
  input logic [AW-1:0] cur_idx,
  input logic [3:0]    gpio_o,
  input logic          trig_o
);
  a_r2_state_legal: assert property (@(posedge clk) disable iff (rst)
    run_state != 2'd3);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0) |-> (cur_idx == '0 && gpio_o == '0));

  a_r2_start_enters: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && ctl_start && !ctl_stop) |=> (run_state == 2'd1 && cur_idx == '0));

  a_r2_stop_wins: assert property (@(posedge clk) disable iff (rst)
    ctl_stop |=> run_state == 2'd0);

  a_r12_pause_freezes: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd2 && !ctl_start && !ctl_stop)
      |=> (run_state == 2'd2 && $stable(cur_idx) && $stable(gpio_o)));

  a_r11_no_trig_paused: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> run_state != 2'd2);
endmodule

bind evseq_top evseq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
  .run_state(run_state), .cur_idx(cur_idx), .gpio_o(gpio_o), .trig_o(trig_o)
);

// File: tb/evseq_top_tb_top.sv
`timescale 1ns/1ps
module evseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_start = 0, ctl_stop = 0, ctl_pause = 0;
  logic        tbl_we = 0;
  logic [3:0]  tbl_waddr = 0;
  logic [23:0] tbl_wdata = 0;
  logic [3:0]  fw_trig = 0, hw_trig = 0, ev_sticky = 0, ev_live = 0;
  logic [1:0]  run_state;
  logic [3:0]  cur_idx, gpio_o;
  logic        trig_o;
  int total = 0, bad = 0, cyc = 0;

  evseq_top dut_i (
    .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_pause(ctl_pause),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .fw_trig(fw_trig), .hw_trig(hw_trig), .ev_sticky(ev_sticky), .ev_live(ev_live),
    .run_state(run_state), .cur_idx(cur_idx), .gpio_o(gpio_o), .trig_o(trig_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [23:0] mk(input int act, input int cs, input int tgt,
                                     input int cnt, input int gp, input int it);
    return {act[2:0], cs[3:0], tgt[3:0], cnt[7:0], gp[3:0], it[0]};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [23:0] d);
    tbl_we = 1; tbl_waddr = idx[3:0]; tbl_wdata = d;
    step();
    tbl_we = 0;
  endtask

  task automatic go();
    step();
    ctl_start = 1; step(); ctl_start = 0;
  endtask

  task automatic halt_now();
    ctl_stop = 1; step(); ctl_stop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      if (run_state == 2'd0) break;
      step();
    end
  endtask

  task automatic run_once(output int idx);
    go(); step(); idx = cur_idx; wait_idle();
  endtask

  initial begin
    int n, tr, idx, c, tk, exp_i;
    repeat (3) step();
    rst = 0;
    step();
    chk("R2 reset state", run_state, 0);
    chk("R2 reset index", cur_idx, 0);
    chk("R11 reset gpio", gpio_o, 0);
    chk("R11 reset trig", trig_o, 0);

    // step chain, gpio and trigger timing
    wr(0, mk(1, 0, 0, 0, 1, 1));
    wr(1, mk(1, 0, 0, 0, 2, 0));
    wr(2, mk(0, 0, 0, 0, 5, 0));
    go();
    chk("R2 start state", run_state, 1);
    chk("R2 start index", cur_idx, 0);
    step();
    chk("R1 R3 step index", cur_idx, 1);
    chk("R11 gpio row0", gpio_o, 1);
    chk("R11 trig row0", trig_o, 1);
    step();
    chk("R3 step index 2", cur_idx, 2);
    chk("R11 gpio row1", gpio_o, 2);
    chk("R11 trig row1", trig_o, 0);
    step();
    chk("R3 halt state", run_state, 0);
    chk("R3 halt index", cur_idx, 0);
    chk("R11 halt gpio", gpio_o, 0);

    // interval wait sweep
    for (int k = 0; k < 4; k++) begin
      int cnt;
      cnt = (k == 3) ? 7 : k;
      wr(0, mk(2, 2, 0, cnt, 3, 1));
      wr(1, mk(0, 0, 0, 0, 0, 0));
      go();
      n = 0; tr = 0;
      for (int i = 0; i < 50; i++) begin
        step(); n++; tr += trig_o;
        if (cur_idx != 0 || run_state == 0) break;
      end
      chk("R7 interval residence", n, cnt + 1);
      chk("R11 single trig during wait", tr, 1);
      wait_idle();
    end

    // loop counter sweep
    for (int k = 0; k < 4; k++) begin
      wr(0, mk(1, 0, 0, 0, 1, 1));
      wr(1, mk(4, 2, 0, k, 0, 0));
      wr(2, mk(0, 0, 0, 0, 0, 0));
      go();
      tr = 0;
      for (int i = 0; i < 60; i++) begin
        step(); tr += trig_o;
        if (run_state == 0) break;
      end
      chk("R8 loop body count", tr, k + 1);
    end

    // sticky waits: triggers (fw/hw) and external sticky lines
    for (int k = 0; k < 8; k++) begin
      wr(0, mk(2, 3 + k, 0, 0, 10, 0));
      wr(1, mk(0, 0, 0, 0, 0, 0));
      go();
      repeat (4) step();
      chk("R4 wait holds index", cur_idx, 0);
      chk("R4 wait holds state", run_state, 1);
      chk("R11 gpio during wait", gpio_o, 10);
      if (k < 4) begin
        if (k % 2 == 0) fw_trig[k] = 1; else hw_trig[k] = 1;
      end else ev_sticky[k-4] = 1;
      step();
      fw_trig = 0; hw_trig = 0; ev_sticky = 0;
      wait_idle();
      chk("R9 sticky event releases wait", run_state, 0);
      go();
      repeat (4) step();
      chk("R9 wait consumed event", cur_idx, 0);
      halt_now();
      chk("R2 stop state", run_state, 0);
      chk("R2 stop gpio", gpio_o, 0);
    end

    // jump decisions on constants and live events
    wr(1, mk(0, 0, 0, 0, 0, 0));
    wr(5, mk(0, 0, 0, 0, 0, 0));
    for (int a = 0; a < 2; a++) begin
      for (int cs = 0; cs < 6; cs++) begin
        for (int lv = 0; lv < 2; lv++) begin
          int sel;
          sel = (cs < 2) ? cs : 9 + cs;
          wr(0, mk(a == 0 ? 3 : 4, sel, 5, 0, 0, 0));
          ev_live = 4'hF; step();
          ev_live = (lv == 1) ? 4'hF : 4'h0;
          if (cs >= 2 && lv == 1) ev_live = 4'(1 << (cs - 2));
          c = (cs == 0) ? 0 : (cs == 1) ? 1 : lv;
          tk = (a == 0) ? c : 1 - c;
          exp_i = tk ? 5 : 1;
          run_once(idx);
          chk("R5 R6 R10 jump target", idx, exp_i);
          ev_live = 0;
        end
      end
    end

    // plain vs clearing jumps on external sticky 0 (select 7)
    wr(1, mk(0, 0, 0, 0, 0, 0));
    wr(2, mk(0, 0, 0, 0, 0, 0));
    ev_sticky[0] = 1; step(); ev_sticky = 0;
    wr(0, mk(3, 7, 2, 0, 0, 0));
    run_once(idx); chk("R9 plain jump sees event", idx, 2);
    run_once(idx); chk("R9 plain jump keeps event", idx, 2);
    wr(0, mk(5, 7, 2, 0, 0, 0));
    run_once(idx); chk("R9 clr jump sees event", idx, 2);
    run_once(idx); chk("R9 clr jump cleared event", idx, 1);
    ev_sticky[0] = 1; step(); ev_sticky = 0;
    wr(0, mk(6, 7, 2, 0, 0, 0));
    run_once(idx); chk("R9 clr false-jump advances", idx, 1);
    run_once(idx); chk("R9 clr false-jump cleared", idx, 2);

    // pause and resume
    ctl_pause = 1; step(); ctl_pause = 0;
    chk("R12 pause ignored when stopped", run_state, 0);
    wr(0, mk(2, 2, 0, 10, 6, 0));
    wr(1, mk(0, 0, 0, 0, 0, 0));
    go();
    repeat (3) step();
    ctl_start = 1; step(); ctl_start = 0;
    chk("R12 start ignored when running", cur_idx, 0);
    ctl_pause = 1; step(); ctl_pause = 0;
    chk("R12 paused state", run_state, 2);
    repeat (20) step();
    chk("R12 paused index", cur_idx, 0);
    chk("R12 paused gpio", gpio_o, 6);
    ctl_start = 1; step(); ctl_start = 0;
    chk("R12 resumed state", run_state, 1);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      step(); n++;
      if (cur_idx != 0 || run_state == 0) break;
    end
    chk("R12 R7 remaining wait after resume", n, 7);
    wait_idle();

    // set/clear collision on trigger 0
    wr(0, mk(2, 3, 0, 0, 0, 0));
    wr(1, mk(2, 3, 0, 0, 0, 0));
    wr(2, mk(0, 0, 0, 0, 0, 0));
    go(); repeat (2) step();
    fw_trig[0] = 1; step(); fw_trig = 0;
    repeat (6) step();
    chk("R9 single pulse parks at row1 idx", cur_idx, 1);
    chk("R9 single pulse parks at row1 state", run_state, 1);
    halt_now();
    go(); repeat (2) step();
    fw_trig[0] = 1; step(); fw_trig = 0; hw_trig[0] = 1; step(); hw_trig = 0;
    repeat (6) step();
    chk("R9 set beats clear", run_state, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule